// File: doc/BRIEF.md
# Hit Count Record Formatter

For every accepted event this block assembles the seven-word hit-count record of a 48-channel time-to-digital chip. A one-cycle start pulse freezes the event's inputs: a raw hit count and a mask bit for each channel, plus the bunch crossing number, the number of hit-data words, the level-2 buffer number, the chip serial bit and the module ID. The block then sends the record out as a stream of 32-bit words, one word per cycle, qualified by a valid flag.

The first six words pack 4-bit channel nibbles, eight channels to a word. In each nibble, bit 3 marks the channel as enabled and bits 2..0 hold its count, limited to four. The seventh word is the header, and a last flag marks it. Counting the hits and giving bus access to the record are both done elsewhere.

Top module: `hitcnt_fmt`

## Requirements
- R1: A start pulse sampled while the block is idle makes `valid_o` rise one cycle later. It stays high for exactly seven consecutive cycles.
- R2: Output word k, for k from 0 to 5, carries channels 8k to 8k+7. Channel 8k+j sits in bits 4j+3..4j, so channel 8k is in bits 3..0 and channel 8k+7 is in bits 31..28.
- R3: Bit 3 of a channel nibble is 1 when the channel's mask bit is 0, and 0 when the mask bit is 1.
- R4: Bits 2..0 of a channel nibble hold the channel's count when that count is four or less. They hold 4 when the count is larger.
- R5: In the seventh word (the header), bits 7..0 carry the bunch crossing number and bits 17..8 carry the hit-data word total.
- R6: Header bits 19..18 carry the level-2 buffer number, and header bit 20 is always 0.
- R7: Header bit 21 is the chip serial bit, bit 22 is always 1, and bits 31..23 carry the 9-bit module ID.
- R8: `last_o` is high only during the seventh valid cycle. `valid_o` is low in the cycle after it.
- R9: A start pulse that arrives while a record is being sent is ignored. The record in flight reflects only the inputs sampled with the accepted start; later input changes do not affect it.
- R10: After reset, and whenever `valid_o` is low, `word_o` is zero and `last_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start of a record; samples all event inputs |
| counts_i | input | 192 | Raw 4-bit hit count per channel, channel c at bits 4c+3..4c |
| mask_i | input | 48 | Channel mask, 1 = channel off |
| bx_i | input | 8 | Bunch crossing number |
| nhits_i | input | 10 | Hit-data word total |
| buf_i | input | 2 | Level-2 buffer number |
| serial_i | input | 1 | Chip serial bit |
| modid_i | input | 9 | Module ID |
| word_o | output | 32 | Record word |
| valid_o | output | 1 | Word valid |
| last_o | output | 1 | Header (final) word |

## Verification
A wrong word index in the sequencer shows at the ports on the first valid cycle. It appears as a nibble group shifted by a word, or as the header arriving early. A missed wrap of the index shows up as a run of valid cycles of the wrong length, or as `last_o` on the wrong word. A snapshot register that fails to hold its value shows up when the bench scrambles the inputs and pulses start in the middle of a record. From that cycle on, the words differ from the values computed from the inputs that were sampled.

// File: rtl/hitcnt_pkg.sv
package hitcnt_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned NIB_W      = 4;
  localparam int unsigned CH_PER_WD  = WORD_W / NIB_W;
  localparam int unsigned SAT_MAX    = 4;
  localparam int unsigned BX_W       = 8;
  localparam int unsigned NHITS_W    = 10;
  localparam int unsigned BUF_W      = 2;
  localparam int unsigned MODID_W    = 9;

  typedef struct packed {
    logic [MODID_W-1:0] modid;
    logic               tdc_type;
    logic               serial;
    logic               spare;
    logic [BUF_W-1:0]   buf_num;
    logic [NHITS_W-1:0] nhits;
    logic [BX_W-1:0]    bx;
  } hdr_t;
endpackage

// File: rtl/hitcnt_pack.sv
module hitcnt_pack
  import hitcnt_pkg::*;
#(
  parameter int unsigned NUM_CH = 48,
  parameter int unsigned CNT_W  = 4
) (
  input  logic [NUM_CH*CNT_W-1:0] counts_i,
  input  logic [NUM_CH-1:0]       mask_i,
  output logic [NUM_CH*NIB_W-1:0] nib_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CNT_W-1:0]   raw;
    logic [NIB_W-2:0]   sat;
    assign raw = counts_i[c*CNT_W +: CNT_W];
    assign sat = (raw > CNT_W'(SAT_MAX)) ? (NIB_W-1)'(SAT_MAX) : raw[NIB_W-2:0];
    assign nib_o[c*NIB_W +: NIB_W] = {~mask_i[c], sat};
  end
endmodule

// File: rtl/hitcnt_hdr.sv
module hitcnt_hdr
  import hitcnt_pkg::*;
(
  input  logic [BX_W-1:0]    bx_i,
  input  logic [NHITS_W-1:0] nhits_i,
  input  logic [BUF_W-1:0]   buf_i,
  input  logic               serial_i,
  input  logic [MODID_W-1:0] modid_i,
  output logic [WORD_W-1:0]  hdr_o
);
  hdr_t hdr;
  always_comb begin
    hdr.modid    = modid_i;
    hdr.tdc_type = 1'b1;
    hdr.serial   = serial_i;
    hdr.spare    = 1'b0;
    hdr.buf_num  = buf_i;
    hdr.nhits    = nhits_i;
    hdr.bx       = bx_i;
  end
  assign hdr_o = hdr;
endmodule

// File: rtl/hitcnt_seq.sv
module hitcnt_seq #(
  parameter int unsigned NUM_WORDS = 7,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             active_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  assign load_o = start_i & ~active_q;  // start ignored while sending

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (load_o) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q) begin
      if (idx_q == LAST_IDX) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign idx_o    = idx_q;
  assign last_o   = active_q && (idx_q == LAST_IDX);
endmodule

// File: rtl/hitcnt_fmt.sv
module hitcnt_fmt
  import hitcnt_pkg::*;
#(
  parameter int unsigned NUM_CH = 48,
  parameter int unsigned CNT_W  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [NUM_CH*CNT_W-1:0] counts_i,
  input  logic [NUM_CH-1:0]       mask_i,
  input  logic [BX_W-1:0]         bx_i,
  input  logic [NHITS_W-1:0]      nhits_i,
  input  logic [BUF_W-1:0]        buf_i,
  input  logic                    serial_i,
  input  logic [MODID_W-1:0]      modid_i,
  output logic [WORD_W-1:0]       word_o,
  output logic                    valid_o,
  output logic                    last_o
);
  localparam int unsigned NUM_CNT_WDS = NUM_CH / CH_PER_WD;
  localparam int unsigned NUM_WORDS   = NUM_CNT_WDS + 1;
  localparam int unsigned IDX_W       = $clog2(NUM_WORDS);

  logic [NUM_CH*NIB_W-1:0] nib;
  logic [WORD_W-1:0]       hdr;
  logic                    load, active, last;
  logic [IDX_W-1:0]        idx;
  logic [WORD_W-1:0]       rec_q [NUM_WORDS];

  hitcnt_pack #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_pack (
    .counts_i (counts_i),
    .mask_i   (mask_i),
    .nib_o    (nib)
  );

  hitcnt_hdr u_hdr (
    .bx_i     (bx_i),
    .nhits_i  (nhits_i),
    .buf_i    (buf_i),
    .serial_i (serial_i),
    .modid_i  (modid_i),
    .hdr_o    (hdr)
  );

  hitcnt_seq #(.NUM_WORDS(NUM_WORDS)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .load_o   (load),
    .active_o (active),
    .last_o   (last),
    .idx_o    (idx)
  );

  // snapshot the whole record on an accepted start
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_rec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rec_q[w] <= '0;
      else if (load) rec_q[w] <= (w == NUM_WORDS - 1) ? hdr : nib[w*WORD_W +: WORD_W];
    end
  end

  assign valid_o = active;
  assign last_o  = last;
  assign word_o  = active ? rec_q[idx] : '0;
endmodule

// File: rtl/hitcnt_fmt_chk.sv
module hitcnt_fmt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [31:0] word_o,
  input logic        valid_o,
  input logic        last_o
);
  logic [2:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (valid_o) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  function automatic logic nibs_ok(logic [31:0] w);
    logic ok = 1'b1;
    for (int j = 0; j < 8; j++) if (w[j*4 +: 3] > 3'd4) ok = 1'b0;
    return ok;
  endfunction

  p_rise_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(start_i));
  p_run_short_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |-> (run_q < 3'd6));
  p_run_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> (valid_o && run_q == 3'd6));
  p_last_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !valid_o);
  p_hold_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |=> valid_o);
  p_nib_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |-> nibs_ok(word_o));
  p_hdr_spare_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> !word_o[20]);
  p_hdr_type_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> word_o[22]);
  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (word_o == '0 && !last_o));
endmodule

bind hitcnt_fmt hitcnt_fmt_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .word_o  (word_o),
  .valid_o (valid_o),
  .last_o  (last_o)
);

// File: tb/hitcnt_fmt_test.sv
module hitcnt_fmt_test;
  localparam int NCH = 48;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [NCH*4-1:0] counts_i = '0;
  logic [NCH-1:0]   mask_i = '0;
  logic [7:0]    bx_i = '0;
  logic [9:0]    nhits_i = '0;
  logic [1:0]    buf_i = '0;
  logic          serial_i = 1'b0;
  logic [8:0]    modid_i = '0;
  logic [31:0]   word_o;
  logic          valid_o, last_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [3:0]  s_cnt [NCH];
  logic [NCH-1:0] s_mask;
  logic [7:0]  s_bx;
  logic [9:0]  s_nh;
  logic [1:0]  s_buf;
  logic        s_ser;
  logic [8:0]  s_mod;

  always #10 clk_i = ~clk_i;

  hitcnt_fmt uut (
    .clk_i, .rst_ni, .start_i, .counts_i, .mask_i, .bx_i, .nhits_i,
    .buf_i, .serial_i, .modid_i, .word_o, .valid_o, .last_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_word(int k);
    logic [31:0] w = '0;
    if (k < 6) begin
      for (int j = 0; j < 8; j++) begin
        logic [3:0] n = (s_cnt[8*k+j] > 4'd4) ? 4'd4 : s_cnt[8*k+j];
        w[j*4 +: 4] = {~s_mask[8*k+j], n[2:0]};
      end
    end else begin
      w = {s_mod, 1'b1, s_ser, 1'b0, s_buf, s_nh, s_bx};
    end
    return w;
  endfunction

  task automatic drive_stim();
    for (int c = 0; c < NCH; c++) counts_i[c*4 +: 4] = s_cnt[c];
    mask_i = s_mask; bx_i = s_bx; nhits_i = s_nh;
    buf_i = s_buf; serial_i = s_ser; modid_i = s_mod;
  endtask

  task automatic scramble();
    for (int c = 0; c < NCH; c++) counts_i[c*4 +: 4] = 4'($urandom);
    mask_i = {16'($urandom), 32'($urandom)};
    bx_i = 8'($urandom); nhits_i = 10'($urandom);
    buf_i = 2'($urandom); serial_i = 1'($urandom); modid_i = 9'($urandom);
  endtask

  task automatic rand_stim();
    for (int c = 0; c < NCH; c++) s_cnt[c] = 4'($urandom);
    s_mask = {16'($urandom), 32'($urandom)};
    s_bx = 8'($urandom); s_nh = 10'($urandom); s_buf = 2'($urandom);
    s_ser = 1'($urandom); s_mod = 9'($urandom);
  endtask

  task automatic run_event(bit disturb);
    @(negedge clk_i);
    drive_stim();
    start_i = 1'b1;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk_i);
      start_i = (disturb && k == 2);
      if (disturb && k == 0) scramble();  // R9: late input changes ignored
      check("R1 valid", {31'd0, valid_o}, 32'd1);
      check("R8 last", {31'd0, last_o}, {31'd0, k == 6});
      if (k < 6) check("R2,R3,R4 count word", word_o, exp_word(k));
      else       check("R5,R6,R7 header", word_o, exp_word(k));
    end
    @(negedge clk_i);
    start_i = 1'b0;
    check("R1,R8 end of run", {30'd0, valid_o, last_o}, 32'd0);
    check("R10 idle word", word_o, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk_i);
    check("R10 reset valid/last", {30'd0, valid_o, last_o}, 32'd0);
    check("R10 reset word", word_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 idle after reset", {word_o[29:0], valid_o, last_o}, 32'd0);

    // saturation: all counts 15, all enabled
    for (int c = 0; c < NCH; c++) s_cnt[c] = 4'd15;
    s_mask = '0; s_bx = 8'hFF; s_nh = 10'h3FF; s_buf = 2'd3; s_ser = 1'b1; s_mod = 9'h1FF;
    run_event(1'b0);
    // R3: all masked, zero counts, header fields zero
    for (int c = 0; c < NCH; c++) s_cnt[c] = 4'd0;
    s_mask = '1; s_bx = 8'h00; s_nh = 10'h000; s_buf = 2'd0; s_ser = 1'b0; s_mod = 9'h000;
    run_event(1'b0);
    // R4 boundary: 4 and 5 alternating, distinct per-channel pattern for R2
    for (int c = 0; c < NCH; c++) s_cnt[c] = (c % 2 == 0) ? 4'd4 : 4'd5;
    s_mask = 48'hA5A5_0F0F_3C3C; s_bx = 8'h5A; s_nh = 10'h155; s_buf = 2'd2; s_ser = 1'b0; s_mod = 9'h0AA;
    run_event(1'b1);
    for (int c = 0; c < NCH; c++) s_cnt[c] = 4'(c % 5);
    s_mask = 48'h0000_0000_0001; s_bx = 8'h01; s_nh = 10'h200; s_buf = 2'd1; s_ser = 1'b1; s_mod = 9'h100;
    run_event(1'b0);

    for (int e = 0; e < 30; e++) begin
      rand_stim();
      run_event(e % 2 == 1);
      repeat ($urandom % 3) @(negedge clk_i);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule